// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Execute Unit

This combinational unit executes the second byte of a two-byte prefixed instruction of an 8-bit processor on one operand byte. The byte is split into three fields. The top two bits pick an operation group. The middle three bits pick either the shift or rotate variant or a bit index. The low three bits name the operand slot. From the operand value and the current flag nibble, the unit returns the new operand value, a write strobe, and the updated flag nibble.

The surrounding core selects the operand register and performs any memory access. It also owns timing. To stretch timing, it uses a separate output that marks the memory-indirect operand slot. When the slot is a register, the instruction takes 8 ticks. When it is indirect, a bit test takes 12 ticks and every other operation takes 16.

Top module: `prefixUnit`

## Requirements
- R1: `isIndirect` is 1 exactly when `opcode[2:0]` equals 6. The slots in `opcode[2:0]` order are B, C, D, E, H, L, memory at HL, A.
- R2: Circular rotates. Opcodes 0x00–0x07 rotate the operand left, with the old bit 7 entering bit 0. Opcodes 0x08–0x0F rotate it right, with the old bit 0 entering bit 7. In both cases flag C receives the bit that moved out.
- R3: Rotates through carry. Opcodes 0x10–0x17 shift left with the incoming C entering bit 0, and C receives the old bit 7. Opcodes 0x18–0x1F shift right with the incoming C entering bit 7, and C receives the old bit 0.
- R4: Shifts. 0x20–0x27 shifts left and fills bit 0 with 0. 0x28–0x2F shifts right and keeps bit 7. 0x38–0x3F shifts right and fills bit 7 with 0. In each case C receives the bit shifted out.
- R5: Opcodes 0x30–0x37 exchange the two nibbles. C becomes 0.
- R6: For every opcode below 0x40, Z is 1 exactly when the result is zero, and N and H are 0. Flag nibble layout in `flagsIn` and `flagsOut`: bit 3 = Z, bit 2 = N, bit 1 = H, bit 0 = C.
- R7: Opcodes 0x40–0x7F test the bit indexed by `opcode[5:3]`. Z becomes the inverse of that bit, N becomes 0, H becomes 1, and C keeps its input value. `writeEn` is 0 and `result` equals the operand.
- R8: Opcodes 0x80–0xBF clear the indexed bit, and 0xC0–0xFF set it. All other bits pass through, and `flagsOut` equals `flagsIn`.
- R9: `writeEn` is 1 for every opcode outside 0x40–0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 8 | Second byte of the prefixed instruction |
| operand | input | 8 | Current value of the selected operand |
| flagsIn | input | 4 | Current flags {Z,N,H,C} |
| result | output | 8 | New operand value |
| writeEn | output | 1 | Result must be written back |
| flagsOut | output | 4 | Updated flags {Z,N,H,C} |
| isIndirect | output | 1 | Operand is the memory-at-HL slot |

## Verification
In a rotate through carry, the incoming carry flag and the outgoing shifted bit meet in the same evaluation. The old C enters the result while the new C is taken from the opposite end. A swapped implementation would therefore corrupt both the result and the flag together. The sweep drives both carry values against every operand byte for each of these opcodes and compares the result and C independently. It also checks that bit test passes the same incoming C straight through while computing Z from a different bit.

// File: rtl/prefixPkg.sv
package prefixPkg;
  parameter int DATA_W = 8;
  localparam int IDX_W = $clog2(DATA_W);
  localparam int FLAG_Z = 3;
  localparam int FLAG_N = 2;
  localparam int FLAG_H = 1;
  localparam int FLAG_C = 0;
  localparam logic [2:0] INDIRECT_SLOT = 3'd6;

  typedef enum logic [2:0] {
    SH_ROT_L   = 3'd0,
    SH_ROT_R   = 3'd1,
    SH_RCY_L   = 3'd2,
    SH_RCY_R   = 3'd3,
    SH_ARITH_L = 3'd4,
    SH_ARITH_R = 3'd5,
    SH_NIBBLE  = 3'd6,
    SH_LOGIC_R = 3'd7
  } shiftOpE;

  typedef struct packed {
    logic              doShift;
    logic              doTest;
    logic              doClear;
    logic              doSet;
    shiftOpE           shiftOp;
    logic [IDX_W-1:0]  bitIdx;
  } ctrlS;
endpackage

// File: rtl/prefixCtrl.sv
module prefixCtrl
  import prefixPkg::*;
(
  input  logic [7:0] opcode,
  output ctrlS       ctrl,
  output logic       writeEn,
  output logic       isIndirect
);
  always_comb begin
    ctrl.doShift = (opcode[7:6] == 2'b00);
    ctrl.doTest  = (opcode[7:6] == 2'b01);
    ctrl.doClear = (opcode[7:6] == 2'b10);
    ctrl.doSet   = (opcode[7:6] == 2'b11);
    ctrl.shiftOp = shiftOpE'(opcode[5:3]);
    ctrl.bitIdx  = IDX_W'(opcode[5:3]);
    writeEn      = ~ctrl.doTest;
    isIndirect   = (opcode[2:0] == INDIRECT_SLOT);
  end
endmodule

// File: rtl/prefixDatapath.sv
module prefixDatapath
  import prefixPkg::*;
(
  input  ctrlS              ctrl,
  input  logic [DATA_W-1:0] operand,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flagsOut
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] shiftRes;
  logic              shiftOut;
  logic [DATA_W-1:0] bitMask;
  logic              carryIn;

  assign carryIn = flagsIn[FLAG_C];
  assign bitMask = {{(DATA_W-1){1'b0}}, 1'b1} << ctrl.bitIdx;

  always_comb begin
    shiftRes = operand;
    shiftOut = 1'b0;
    unique case (ctrl.shiftOp)
      SH_ROT_L: begin
        shiftRes = {operand[DATA_W-2:0], operand[DATA_W-1]};
        shiftOut = operand[DATA_W-1];
      end
      SH_ROT_R: begin
        shiftRes = {operand[0], operand[DATA_W-1:1]};
        shiftOut = operand[0];
      end
      SH_RCY_L: begin
        shiftRes = {operand[DATA_W-2:0], carryIn};
        shiftOut = operand[DATA_W-1];
      end
      SH_RCY_R: begin
        shiftRes = {carryIn, operand[DATA_W-1:1]};
        shiftOut = operand[0];
      end
      SH_ARITH_L: begin
        shiftRes = {operand[DATA_W-2:0], 1'b0};
        shiftOut = operand[DATA_W-1];
      end
      SH_ARITH_R: begin
        shiftRes = {operand[DATA_W-1], operand[DATA_W-1:1]};
        shiftOut = operand[0];
      end
      SH_NIBBLE: begin
        shiftRes = {operand[HALF-1:0], operand[DATA_W-1:HALF]};
        shiftOut = 1'b0;
      end
      SH_LOGIC_R: begin
        shiftRes = {1'b0, operand[DATA_W-1:1]};
        shiftOut = operand[0];
      end
      default: ;
    endcase
  end

  always_comb begin
    result   = operand;
    flagsOut = flagsIn;
    if (ctrl.doShift) begin
      result           = shiftRes;
      flagsOut[FLAG_Z] = (shiftRes == '0);
      flagsOut[FLAG_N] = 1'b0;
      flagsOut[FLAG_H] = 1'b0;
      flagsOut[FLAG_C] = shiftOut;
    end else if (ctrl.doTest) begin
      flagsOut[FLAG_Z] = ~|(operand & bitMask);
      flagsOut[FLAG_N] = 1'b0;
      flagsOut[FLAG_H] = 1'b1;
    end else if (ctrl.doClear) begin
      result = operand & ~bitMask;
    end else if (ctrl.doSet) begin
      result = operand | bitMask;
    end
  end
endmodule

// File: rtl/prefixUnit.sv
module prefixUnit
  import prefixPkg::*;
(
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] operand,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic [3:0]        flagsOut,
  output logic              isIndirect
);
  ctrlS ctrl;

  prefixCtrl uCtrl (
    .opcode     (opcode),
    .ctrl       (ctrl),
    .writeEn    (writeEn),
    .isIndirect (isIndirect)
  );

  prefixDatapath uDp (
    .ctrl     (ctrl),
    .operand  (operand),
    .flagsIn  (flagsIn),
    .result   (result),
    .flagsOut (flagsOut)
  );
endmodule

// File: rtl/prefixUnitChecker.sv
module prefixUnitChecker
  import prefixPkg::*;
(
  input logic [7:0]        opcode,
  input logic [DATA_W-1:0] operand,
  input logic [3:0]        flagsIn,
  input logic [DATA_W-1:0] result,
  input logic              writeEn,
  input logic [3:0]        flagsOut,
  input logic              isIndirect
);
  always_comb begin
    AST_TEST_NO_WRITE: assert (opcode[7:6] != 2'b01 || (!writeEn && result == operand)); // R7
    AST_TEST_FLAGS: assert (opcode[7:6] != 2'b01 ||
      (flagsOut[FLAG_H] && !flagsOut[FLAG_N] && flagsOut[FLAG_C] == flagsIn[FLAG_C])); // R7
    AST_BITOP_FLAGS_KEEP: assert (!opcode[7] || flagsOut == flagsIn); // R8
    AST_BITOP_WRITES: assert (opcode[7:6] == 2'b01 || writeEn); // R9
    AST_SHIFT_ZERO_FLAG: assert (opcode[7:6] != 2'b00 ||
      (flagsOut[FLAG_Z] == (result == '0) && !flagsOut[FLAG_N] && !flagsOut[FLAG_H])); // R6
    AST_SWAP_CARRY_CLR: assert (opcode[7:3] != 5'b00110 || !flagsOut[FLAG_C]); // R5
    AST_SLOT_INDIRECT: assert (isIndirect == (opcode[2:0] == 3'd6)); // R1
  end
endmodule

bind prefixUnit prefixUnitChecker uChk (
  .opcode     (opcode),
  .operand    (operand),
  .flagsIn    (flagsIn),
  .result     (result),
  .writeEn    (writeEn),
  .flagsOut   (flagsOut),
  .isIndirect (isIndirect)
);

// File: tb/sim_prefixUnit.sv
module sim_prefixUnit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opcode = 8'h00;
  logic [7:0] operand = 8'h00;
  logic [3:0] flagsIn = 4'h0;
  logic [7:0] result;
  logic       writeEn;
  logic [3:0] flagsOut;
  logic       isIndirect;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  prefixUnit u0 (
    .opcode(opcode), .operand(operand), .flagsIn(flagsIn),
    .result(result), .writeEn(writeEn), .flagsOut(flagsOut),
    .isIndirect(isIndirect)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s op=%02h val=%02h fin=%01h actual=%0h expected=%0h",
               tag, what, opcode, operand, flagsIn, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 200000 && !finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=<200000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] expRes;
    logic [3:0] expFl;
    logic       c;
    logic       outBit;
    string      tag;
    repeat (3) @(posedge clk);
    // reset-time check: swap of zero gives Z=1, C=0 (R5)
    opcode = 8'h37; operand = 8'h00; flagsIn = 4'hF;
    @(negedge clk);
    check("R5", "reset-time flags", flagsOut, 4'b1000);
    check("R5", "reset-time result", result, 0);
    rst = 1'b0;
    for (int op = 0; op < 256; op++) begin
      for (int v = 0; v < 256; v++) begin
        for (int ci = 0; ci < 2; ci++) begin
          @(posedge clk);
          opcode  = 8'(op);
          operand = 8'(v);
          flagsIn = {3'(v ^ (op >> 2)), 1'(ci)};
          c = 1'(ci);
          @(negedge clk);
          expRes = operand;
          expFl  = flagsIn;
          outBit = 1'b0;
          tag    = "R8";
          if (op < 64) begin
            case ((op >> 3) & 7)
              0: begin expRes = 8'((v << 1) | (v >> 7)); outBit = v[7]; tag = "R2"; end
              1: begin expRes = 8'((v >> 1) | (v << 7)); outBit = v[0]; tag = "R2"; end
              2: begin expRes = 8'((v << 1) | ci);       outBit = v[7]; tag = "R3"; end
              3: begin expRes = 8'((v >> 1) | (ci << 7)); outBit = v[0]; tag = "R3"; end
              4: begin expRes = 8'(v << 1);              outBit = v[7]; tag = "R4"; end
              5: begin expRes = 8'((v >> 1) | (v & 128)); outBit = v[0]; tag = "R4"; end
              6: begin expRes = 8'(((v & 15) << 4) | (v >> 4)); outBit = 1'b0; tag = "R5"; end
              default: begin expRes = 8'(v >> 1);        outBit = v[0]; tag = "R4"; end
            endcase
            expFl = {expRes == 8'h00, 1'b0, 1'b0, outBit};
            check(tag, "result", result, expRes);
            check(tag == "R5" ? "R5" : "R6", "flags", flagsOut, expFl);
          end else if (op < 128) begin
            expFl = {~v[(op >> 3) & 7], 1'b0, 1'b1, c};
            check("R7", "result", result, expRes);
            check("R7", "flags", flagsOut, expFl);
          end else begin
            if (op < 192) expRes = 8'(v & ~(1 << ((op >> 3) & 7)));
            else          expRes = 8'(v | (1 << ((op >> 3) & 7)));
            check("R8", "result", result, expRes);
            check("R8", "flags", flagsOut, expFl);
          end
          check(op >= 64 && op < 128 ? "R7" : "R9", "writeEn", writeEn,
                (op >= 64 && op < 128) ? 0 : 1);
          check("R1", "isIndirect", isIndirect, (op & 7) == 6 ? 1 : 0);
        end
      end
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule